// File: doc/BRIEF.md
# PCM serial port with frame-sync detection

This block is the serial side of a voiceband codec. Each 8 kHz frame carries one 8-bit sample in each direction. Transmit and receive each have their own bit clock and frame sync, and the two may run at different rates. A system clock samples the bit clocks, the syncs and the serial input through synchronizer chains. All framing decisions are taken on the edges that the block detects in that clock domain. The system clock must be several times faster than the fastest bit clock, which may be anywhere from 64 kHz to 4.096 MHz.

On every frame the block checks whether the sync is still high on the second falling bit-clock edge after its rising edge. If it is, the frame is long; otherwise it is short. The sync width may change from one frame to the next, because only the rising edges carry timing.

On the transmit side, the parallel byte is captured when a frame starts and is shifted out most significant bit first. Bits change on bit-clock rising edges. An output-enable tells the pad when to drive the line. On the receive side, bits are sampled on falling edges. The assembled byte is presented with a one-cycle strobe once the eighth data bit has been taken.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is applied, and after it until the first frame, tx_sd_oe_o, tx_sd_o and rx_valid_o are 0, and tx_long_o and rx_long_o read 0 (short).
- R2: For each frame, the mode output of that direction reads 1 (long) when the sync was sampled high on both the first and second falling bit-clock edges after its rising edge; otherwise it reads 0 (short). The value is refreshed every frame.
- R3: In a long frame, the transmit line carries bit 7 from the sync rising edge, then bits 6 down to 0 in the following bit-clock periods. Each bit changes on a bit-clock rising edge.
- R4: In a short frame, where the sync is already low at the first bit-clock rising edge after it was sampled, bit 7 starts at that rising edge and bits 6 down to 0 follow one per period.
- R5: tx_sd_oe_o is 1 from the sync rising edge until the end of the eighth data bit period, and also while the sync is high. At all other times it is 0, and tx_sd_o is then 0.
- R6: The transmit byte is taken from tx_word_i at the sync rising edge. Later changes on tx_word_i do not alter the frame in progress.
- R7: In a long frame, the receive bit sampled on the first falling edge after the sync rising edge is the most significant bit, and the next seven falling edges give bits 6 down to 0.
- R8: In a short frame, the sample on the first falling edge is discarded, and the next eight falling edges give bits 7 down to 0.
- R9: rx_valid_o is high for exactly one system-clock cycle per completed word, with rx_word_o updated in that same cycle. rx_word_o holds its value until the next completed word.
- R10: Long-frame sync widths from 2 to 8 bit periods, changing from frame to frame, give correct data in both directions.
- R11: A sync rising edge that arrives while a word is in progress restarts the word. The cut-off receive word produces no strobe, and the new frame carries the newly captured transmit byte.
- R12: Transmit and receive run on independent bit clocks and syncs. Activity on one direction does not disturb the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_bclk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_word_i | input | WORD_W | Byte to send, captured at frame start |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_sd_oe_o | output | 1 | Drive enable for the transmit pad (0 = high impedance) |
| tx_long_o | output | 1 | Sync mode of the current transmit frame (1 = long) |
| rx_bclk_i | input | 1 | Receive bit clock |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_sd_i | input | 1 | Serial receive data |
| rx_word_o | output | WORD_W | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received byte |
| rx_long_o | output | 1 | Sync mode of the current receive frame (1 = long) |

## Verification
The hardest situation to reach is a sync rising edge that lands in the middle of a word. The port must drop the partial receive word without a strobe, and restart transmit with a freshly captured byte. The stimulus runs a short frame for five bit periods and then raises the sync again straight away. It then checks both the strobe count and the restarted data. Both directions are swept over alternating long and short frames, with every long sync width from 2 to 8 periods. The two directions use different bit-clock rates and run concurrently.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/pcm_pin_sync.sv
// Multi-stage level synchronizer for asynchronous serial-side pins.
module pcm_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= in_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcm_sync_class.sv
// Per-frame long/short decision: sync level seen on the first two falling edges.
module pcm_sync_class
  import pcm_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       fall_i,
  input  logic       fs_i,
  output sync_mode_e mode_o
);
  logic [1:0] nfall_q, nfall_d;
  logic       h1_q, h1_d;
  sync_mode_e mode_q, mode_d;

  always_comb begin
    nfall_d = nfall_q;
    h1_d    = h1_q;
    mode_d  = mode_q;
    if (start_i) begin
      nfall_d = 2'd0;
      h1_d    = 1'b0;
    end else if (fall_i && nfall_q != 2'd2) begin
      if (nfall_q == 2'd0) h1_d = fs_i;
      else mode_d = (h1_q && fs_i) ? SYNC_LONG : SYNC_SHORT;
      nfall_d = nfall_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nfall_q <= 2'd2;
      h1_q    <= 1'b0;
      mode_q  <= SYNC_SHORT;
    end else begin
      nfall_q <= nfall_d;
      h1_q    <= h1_d;
      mode_q  <= mode_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pcm_tx_lane.sv
// Transmit direction: captures the byte at frame start, shifts MSB first on bit-clock rises.
module pcm_tx_lane
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fs_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sd_o,
  output logic              oe_o,
  output sync_mode_e        mode_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic [1:0] lvl, dly_q;   // [0] bit clock, [1] frame sync
  logic bclk_rise, bclk_fall, fs_rise;

  pcm_pin_sync #(.W(2), .STAGES(STAGES)) u_pins (
    .clk_i (clk_i), .rst_ni(rst_ni), .in_i({fs_i, bclk_i}), .lvl_o(lvl)
  );

  assign bclk_rise = lvl[0] & ~dly_q[0];
  assign bclk_fall = ~lvl[0] & dly_q[0];
  assign fs_rise   = lvl[1] & ~dly_q[1];

  pcm_sync_class u_class (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(fs_rise),
    .fall_i(bclk_fall), .fs_i(lvl[1]), .mode_o(mode_o)
  );

  logic              active_q, active_d;
  logic              first_q, first_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    active_d = active_q;
    first_d  = first_q;
    idx_d    = idx_q;
    word_d   = word_q;
    if (fs_rise) begin
      active_d = 1'b1;
      first_d  = 1'b1;
      idx_d    = '0;
      word_d   = word_i;
    end else if (bclk_rise && active_q) begin
      if (first_q) begin
        first_d = 1'b0;
        // sync still high: long schedule, bit 7 already had its period
        if (lvl[1]) idx_d = IDX_W'(1);
      end else if (idx_q == LAST) begin
        active_d = 1'b0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= '0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
      idx_q    <= '0;
      word_q   <= '0;
    end else begin
      dly_q    <= lvl;
      active_q <= active_d;
      first_q  <= first_d;
      idx_q    <= idx_d;
      word_q   <= word_d;
    end
  end

  assign sd_o = active_q & word_q[LAST - idx_q];
  assign oe_o = active_q | lvl[1];
endmodule

// File: rtl/pcm_rx_lane.sv
// Receive direction: samples on bit-clock falls, keeps one spare sample for short frames.
module pcm_rx_lane
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output sync_mode_e        mode_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(WORD_W + 1);

  logic [2:0] lvl;          // [0] bit clock, [1] frame sync, [2] data
  logic [1:0] dly_q;
  logic bclk_fall, fs_rise;

  pcm_pin_sync #(.W(3), .STAGES(STAGES)) u_pins (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i({sd_i, fs_i, bclk_i}), .lvl_o(lvl)
  );

  assign bclk_fall = ~lvl[0] & dly_q[0];
  assign fs_rise   = lvl[1] & ~dly_q[1];

  pcm_sync_class u_class (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(fs_rise),
    .fall_i(bclk_fall), .fs_i(lvl[1]), .mode_o(mode_o)
  );

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W:0]   sreg_q, sreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sreg_d   = sreg_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    if (fs_rise) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (bclk_fall && active_q) begin
      sreg_d = {sreg_q[WORD_W-1:0], lvl[2]};
      cnt_d  = cnt_q + CNT_W'(1);
      if ((mode_o == SYNC_LONG && cnt_d == N_LONG) || cnt_d == N_SHORT) begin
        word_d   = sreg_d[WORD_W-1:0];
        valid_d  = 1'b1;
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= '0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sreg_q   <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      dly_q    <= lvl[1:0];
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sreg_q   <= sreg_d;
      word_q   <= word_d;
      valid_q  <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_bclk_i,
  input  logic              tx_fs_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_sd_o,
  output logic              tx_sd_oe_o,
  output logic              tx_long_o,
  input  logic              rx_bclk_i,
  input  logic              rx_fs_i,
  input  logic              rx_sd_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              rx_long_o
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sync_mode_e tx_mode, rx_mode;

  pcm_tx_lane #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_n), .bclk_i(tx_bclk_i), .fs_i(tx_fs_i),
    .word_i(tx_word_i), .sd_o(tx_sd_o), .oe_o(tx_sd_oe_o), .mode_o(tx_mode)
  );

  pcm_rx_lane #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_n), .bclk_i(rx_bclk_i), .fs_i(rx_fs_i),
    .sd_i(rx_sd_i), .word_o(rx_word_o), .valid_o(rx_valid_o), .mode_o(rx_mode)
  );

  assign tx_long_o = (tx_mode == SYNC_LONG);
  assign rx_long_o = (rx_mode == SYNC_LONG);
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_sd_o,
  input logic              tx_sd_oe_o,
  input logic              tx_long_o,
  input logic              rx_long_o,
  input logic [WORD_W-1:0] rx_word_o,
  input logic              rx_valid_o
);
  // R1: quiet outputs while reset is held
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!tx_sd_oe_o && !tx_sd_o && !rx_valid_o && !tx_long_o && !rx_long_o)
        else $error("R1 outputs active during reset");
    end
  end

  // R9: strobe lasts a single cycle
  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R9: received byte only moves together with the strobe
  a_r9_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_word_o));

  // R5: line carries 0 whenever the pad is released
  a_r5_line_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_sd_oe_o |-> !tx_sd_o);
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_sd_o(tx_sd_o), .tx_sd_oe_o(tx_sd_oe_o),
  .tx_long_o(tx_long_o), .rx_long_o(rx_long_o), .rx_word_o(rx_word_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/sim_pcm_serial_port.sv
`timescale 1ns/1ps
module sim_pcm_serial_port;
  localparam int HT = 8;   // transmit half bit period, system cycles
  localparam int HR = 7;   // receive half bit period, system cycles

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_bclk, tx_fs, rx_bclk, rx_fs, rx_sd;
  logic [7:0] tx_word;
  logic       tx_sd, tx_oe, tx_long, rx_valid, rx_long;
  logic [7:0] rx_word;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [7:0] vword = 8'h00;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_bclk_i(tx_bclk), .tx_fs_i(tx_fs), .tx_word_i(tx_word),
    .tx_sd_o(tx_sd), .tx_sd_oe_o(tx_oe), .tx_long_o(tx_long),
    .rx_bclk_i(rx_bclk), .rx_fs_i(rx_fs), .rx_sd_i(rx_sd),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid), .rx_long_o(rx_long)
  );

  always @(posedge clk) begin
    if (rst_n && rx_valid) begin
      vcount = vcount + 1;
      vword  = rx_word;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pick(input int k, input int salt);
    case (k)
      0: pick = 8'h00;
      1: pick = 8'hFF;
      2: pick = 8'h80;
      3: pick = 8'h01;
      default: pick = 8'((k * salt + 29) & 255);
    endcase
  endfunction

  // Transmit frame: the bench acts as the far end and samples at each falling edge.
  task automatic tx_frame(input logic [7:0] w, input bit lng, input int fsb);
    tx_word = w;
    for (int p = 0; p < 10; p++) begin
      tx_bclk = 1'b1;
      tx_fs   = (p == 0) ? 1'b1 : (lng ? (p < fsb) : 1'b0);
      if (p == 1) tx_word = ~w;                // R6: late change must not matter
      wait_n(HT);
      if (p == 2) check("R2 tx mode", 32'(tx_long), 32'(lng));
      if (lng) begin
        if (p < 8) begin
          check("R3 R6 R10 tx long bit", 32'(tx_sd), 32'(w[7-p]));
          check("R5 tx oe in slot", 32'(tx_oe), 32'd1);
        end else begin
          check("R5 tx oe after slot", 32'(tx_oe), 32'(p < fsb));
        end
      end else begin
        if (p == 0) check("R5 tx oe at sync", 32'(tx_oe), 32'd1);
        else if (p <= 8) begin
          check("R4 R6 tx short bit", 32'(tx_sd), 32'(w[8-p]));
          check("R5 tx oe in slot", 32'(tx_oe), 32'd1);
        end else begin
          check("R5 tx oe after slot", 32'(tx_oe), 32'd0);
          check("R5 tx line low", 32'(tx_sd), 32'd0);
        end
      end
      tx_bclk = 1'b0;
      wait_n(HT);
    end
    tx_fs = 1'b0;
  endtask

  // Receive frame: the bench drives data on rising edges.
  task automatic rx_frame(input logic [7:0] w, input bit lng, input int fsb);
    int c0;
    c0 = vcount;
    for (int p = 0; p < 11; p++) begin
      rx_bclk = 1'b1;
      rx_fs   = (p == 0) ? 1'b1 : (lng ? (p < fsb) : 1'b0);
      if (lng) rx_sd = (p < 8) ? w[7-p] : 1'b0;
      else     rx_sd = (p == 0) ? ~w[7] : ((p <= 8) ? w[8-p] : 1'b1);
      wait_n(HR);
      rx_bclk = 1'b0;
      wait_n(HR);
    end
    rx_fs = 1'b0;
    check("R9 one strobe per word", 32'(vcount - c0), 32'd1);
    check(lng ? "R7 R10 rx long word" : "R8 rx short word", 32'(vword), 32'(w));
    check("R9 rx word held", 32'(rx_word), 32'(w));
    check("R2 rx mode", 32'(rx_long), 32'(lng));
  endtask

  task automatic tx_partial(input int n);
    tx_word = 8'hC3;
    for (int p = 0; p < n; p++) begin
      tx_bclk = 1'b1; tx_fs = (p == 0); wait_n(HT);
      tx_bclk = 1'b0; wait_n(HT);
    end
  endtask

  task automatic rx_partial(input int n);
    for (int p = 0; p < n; p++) begin
      rx_bclk = 1'b1; rx_fs = (p == 0); rx_sd = p[0]; wait_n(HR);
      rx_bclk = 1'b0; wait_n(HR);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0;
    tx_bclk = 1'b0; tx_fs = 1'b0; tx_word = 8'h00;
    rx_bclk = 1'b0; rx_fs = 1'b0; rx_sd = 1'b0;
    wait_n(5);
    check("R1 oe in reset", 32'(tx_oe), 32'd0);
    check("R1 strobe in reset", 32'(rx_valid), 32'd0);
    rst_n = 1'b1;
    wait_n(10);
    check("R1 oe idle", 32'(tx_oe), 32'd0);
    check("R1 line idle", 32'(tx_sd), 32'd0);
    check("R1 tx mode idle", 32'(tx_long), 32'd0);
    check("R1 rx mode idle", 32'(rx_long), 32'd0);
    check("R1 rx word idle", 32'(rx_word), 32'd0);

    // Sweep: alternating modes, long widths 2..8, both directions concurrently (R12)
    for (int k = 0; k < 14; k++) begin
      fork
        tx_frame(pick(k, 37), k % 2 == 1, (k % 2 == 1) ? 2 + (k / 2) % 7 : 1);
        rx_frame(pick(k + 4, 53), k % 2 == 0, (k % 2 == 0) ? 2 + (k / 2) % 7 : 1);
      join
    end

    // R11: sync rising mid-word restarts both directions
    c0 = vcount;
    fork
      tx_partial(5);
      rx_partial(5);
    join
    check("R11 no strobe for cut word", 32'(vcount - c0), 32'd0);
    fork
      tx_frame(8'hA6, 1'b1, 3);
      rx_frame(8'h4B, 1'b0, 1);
    join
    check("R11 one strobe after restart", 32'(vcount - c0), 32'd1);

    // R12: receive alone, transmit pins idle
    rx_frame(8'h3C, 1'b1, 5);
    check("R12 tx quiet during rx", 32'(tx_oe), 32'd0);
    check("R12 tx mode unchanged", 32'(tx_long), 32'd1);
    // and transmit alone, received byte unchanged
    c0 = vcount;
    tx_frame(8'h96, 1'b0, 1);
    check("R12 no rx strobe during tx", 32'(vcount - c0), 32'd0);
    check("R12 rx word unchanged", 32'(rx_word), 32'h3C);

    done = 1;
    summary();
    $finish;
  end
endmodule